// File: doc/BRIEF.md
# Exception Condition and Vector Selector

This block looks at the instruction finishing in the current cycle, the machine-state bits and the translation-miss flags, and picks at most one exception to take in that cycle. It reports the pick as a take strobe and a vector offset. When the pick is a program exception, a subtype code says why it was raised. The block also contains its own down-counting decrementer. A pending timer exception is latched when the counter's top bit rises and is held until it is taken.

Surrounding control logic uses `take` and `vector` to redirect fetch. Saving and restoring the state registers is done outside this block. The decrementer can be loaded through a write port and counts down on every tick-enable cycle. Its current value is visible on an output.

Top module: `exc_select`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `take` is 0, `vector` is 0, `prog_kind` is 0 and `dec_value` is 0. No decrementer event is pending.
- R2: An instruction translation miss (`itlb_miss`=1) is taken in any cycle with vector 0x1000. It outranks every other condition.
- R3: When `ins_valid`=1, a program exception is taken with vector 0x700 if any of these holds: the opcode is illegal, a privileged instruction runs while PR=1, or a trap condition is met. `prog_kind` then reads 1 for illegal, 2 for privileged and 3 for trap. If several hold, the code is chosen in that order. `prog_kind` is 0 whenever the selected exception is not a program exception.
- R4: A special-register move with an invalid register field raises a privileged program exception (`prog_kind`=2) only when the field's top bit (`ins_spr_top`) is 1 and PR=1. In every other case that move raises nothing.
- R5: A floating-point instruction (`ins_fp`) raises an exception with vector 0x800 when FP=0. When FP=1 it raises nothing.
- R6: A system call instruction always raises an exception with vector 0xC00.
- R7: A data-load translation miss (`dtlb_miss`) is taken in any cycle with vector 0x1100.
- R8: When `ins_valid`=1, a trace exception with vector 0xD00 is raised if SE=1, or if the instruction is a branch and BE=1.
- R9: The decrementer loads `dec_wdata` when `dec_wr`=1. Otherwise it decreases by one when `dec_tick`=1, wrapping from 0 to all ones. Otherwise it holds its value. A write wins over a tick in the same cycle. The value is shown on `dec_value` from the next cycle on.
- R10: A decrementer event becomes pending in the cycle after the counter's top bit goes from 0 to 1. A pending event is taken with vector 0x900 only while EE=1 and nothing of higher rank is present. It stays pending until it is taken, and it is clear in the cycle after it is taken.
- R11: At most one exception is taken per cycle. The ranks, highest first, are: instruction miss, program, FP unavailable, system call, data-load miss, trace, decrementer. Vector 0xE00 is never produced. When `take`=0, both `vector` and `prog_kind` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | An instruction completes this cycle |
| ins_illegal | input | 1 | Illegal or unimplemented opcode |
| ins_priv | input | 1 | Instruction is privileged |
| ins_sprmove | input | 1 | Instruction is a special-register move |
| ins_spr_bad | input | 1 | Register field of the move is invalid |
| ins_spr_top | input | 1 | Top bit of the move's register field |
| ins_trap_hit | input | 1 | Trap condition met |
| ins_fp | input | 1 | Floating-point instruction, including loads, stores and moves |
| ins_sc | input | 1 | System call instruction |
| ins_branch | input | 1 | Instruction is a branch |
| st_pr | input | 1 | User-mode bit |
| st_fp | input | 1 | Floating-point available bit |
| st_ee | input | 1 | External/timer interrupt enable |
| st_se | input | 1 | Single-step trace enable |
| st_be | input | 1 | Branch trace enable |
| itlb_miss | input | 1 | Instruction translation miss |
| dtlb_miss | input | 1 | Data-load translation miss |
| dec_tick | input | 1 | Decrementer count enable |
| dec_wr | input | 1 | Decrementer load strobe |
| dec_wdata | input | 32 | Decrementer load value |
| dec_value | output | 32 | Current decrementer value |
| take | output | 1 | An exception is taken this cycle |
| vector | output | 16 | Vector offset of the taken exception |
| prog_kind | output | 2 | Program-exception subtype (0 none, 1 illegal, 2 privileged, 3 trap) |

## Verification
The assertions assume that every input carries a known value in every cycle after reset. They also assume that the instruction and state flags are stable for the whole cycle in which they are sampled. The bench meets this by driving every input on the falling clock edge, from a fixed-seed random generator. Single-cycle flags are kept sparse so that low-rank exceptions such as trace and the decrementer still win often. Loads of small values and of values just below the top-bit boundary are frequent, so the decrementer wraps and raises its top bit many times in a run.

// File: rtl/exc_select.sv
module exc_select #(
  parameter int DEC_W = 32,
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic             ins_illegal,
  input  logic             ins_priv,
  input  logic             ins_sprmove,
  input  logic             ins_spr_bad,
  input  logic             ins_spr_top,
  input  logic             ins_trap_hit,
  input  logic             ins_fp,
  input  logic             ins_sc,
  input  logic             ins_branch,
  input  logic             st_pr,
  input  logic             st_fp,
  input  logic             st_ee,
  input  logic             st_se,
  input  logic             st_be,
  input  logic             itlb_miss,
  input  logic             dtlb_miss,
  input  logic             dec_tick,
  input  logic             dec_wr,
  input  logic [DEC_W-1:0] dec_wdata,
  output logic [DEC_W-1:0] dec_value,
  output logic             take,
  output logic [VEC_W-1:0] vector,
  output logic [1:0]       prog_kind
);
  localparam int MSB = DEC_W - 1;
  localparam logic [VEC_W-1:0] V_PROG = VEC_W'(16'h0700);
  localparam logic [VEC_W-1:0] V_FPU  = VEC_W'(16'h0800);
  localparam logic [VEC_W-1:0] V_DEC  = VEC_W'(16'h0900);
  localparam logic [VEC_W-1:0] V_SC   = VEC_W'(16'h0C00);
  localparam logic [VEC_W-1:0] V_TRC  = VEC_W'(16'h0D00);
  localparam logic [VEC_W-1:0] V_IMIS = VEC_W'(16'h1000);
  localparam logic [VEC_W-1:0] V_DMIS = VEC_W'(16'h1100);

  logic [DEC_W-1:0] dec_q, dec_d;
  logic pend_q, dec_sel;

  assign dec_d = dec_wr ? dec_wdata : (dec_tick ? dec_q - DEC_W'(1) : dec_q);
  assign dec_value = dec_q;

  wire c_ill  = ins_valid & ins_illegal;
  wire c_priv = ins_valid & st_pr & (ins_priv | (ins_sprmove & ins_spr_bad & ins_spr_top));
  wire c_trap = ins_valid & ins_trap_hit;
  wire c_prog = c_ill | c_priv | c_trap;
  wire c_fpu  = ins_valid & ins_fp & ~st_fp;
  wire c_sc   = ins_valid & ins_sc;
  wire c_trc  = ins_valid & (st_se | (ins_branch & st_be));
  wire c_dec  = pend_q & st_ee;

  always_comb begin
    take      = 1'b1;
    vector    = '0;
    prog_kind = 2'd0;
    dec_sel   = 1'b0;
    if (itlb_miss)      vector = V_IMIS;
    else if (c_prog) begin
      vector    = V_PROG;
      prog_kind = c_ill ? 2'd1 : (c_priv ? 2'd2 : 2'd3);
    end
    else if (c_fpu)     vector = V_FPU;
    else if (c_sc)      vector = V_SC;
    else if (dtlb_miss) vector = V_DMIS;
    else if (c_trc)     vector = V_TRC;
    else if (c_dec) begin
      vector  = V_DEC;
      dec_sel = 1'b1;
    end
    else                take = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      dec_q <= dec_d;
      if (dec_d[MSB] & ~dec_q[MSB]) pend_q <= 1'b1;
      else if (dec_sel)             pend_q <= 1'b0;
    end
  end

  p_dec_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_wr |=> dec_value == $past(dec_wdata));
  p_dec_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_wr && dec_tick) |=> dec_value == $past(dec_value) - DEC_W'(1));
  p_dec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_wr && !dec_tick) |=> $stable(dec_value));
  p_dec_ee_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vector == V_DEC) |-> st_ee);
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(take && vector == V_DEC)) |=> pend_q);
  p_imiss_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    itlb_miss |-> (take && vector == V_IMIS));
  p_kind_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_kind != 2'd0) |-> (take && vector == V_PROG));
  p_no_assist_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vector != VEC_W'(16'h0E00));
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (vector == '0 && prog_kind == 2'd0));
endmodule

// File: tb/exc_select_tb.sv
module exc_select_tb;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n, ins_valid, ins_illegal, ins_priv, ins_sprmove, ins_spr_bad, ins_spr_top;
  logic ins_trap_hit, ins_fp, ins_sc, ins_branch;
  logic st_pr, st_fp, st_ee, st_se, st_be, itlb_miss, dtlb_miss, dec_tick, dec_wr;
  logic [31:0] dec_wdata, dec_value;
  logic take;
  logic [15:0] vector;
  logic [1:0] prog_kind;

  exc_select u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_dec = 0;
  logic m_pend = 0;
  logic e_take;
  logic [15:0] e_vec;
  logic [1:0] e_kind;

  task automatic calc();
    logic ill, prv, trp;
    ill = ins_valid & ins_illegal;
    prv = ins_valid & st_pr & (ins_priv | (ins_sprmove & ins_spr_bad & ins_spr_top));
    trp = ins_valid & ins_trap_hit;
    e_take = 1; e_kind = 0;
    if (itlb_miss) e_vec = 16'h1000;
    else if (ill | prv | trp) begin
      e_vec = 16'h0700;
      e_kind = ill ? 2'd1 : prv ? 2'd2 : 2'd3;
    end
    else if (ins_valid & ins_fp & ~st_fp) e_vec = 16'h0800;
    else if (ins_valid & ins_sc) e_vec = 16'h0C00;
    else if (dtlb_miss) e_vec = 16'h1100;
    else if (ins_valid & (st_se | (ins_branch & st_be))) e_vec = 16'h0D00;
    else if (m_pend & st_ee) e_vec = 16'h0900;
    else begin e_take = 0; e_vec = 0; end
  endtask

  function automatic string tag_of(logic [15:0] v);
    case (v)
      16'h1000: return "R2";  16'h0700: return "R3";  16'h0800: return "R5";
      16'h0C00: return "R6";  16'h1100: return "R7";  16'h0D00: return "R8";
      16'h0900: return "R10"; default:  return "R11";
    endcase
  endfunction

  task automatic idle();
    {ins_valid, ins_illegal, ins_priv, ins_sprmove, ins_spr_bad, ins_spr_top} = '0;
    {ins_trap_hit, ins_fp, ins_sc, ins_branch, itlb_miss, dtlb_miss} = '0;
    {st_pr, st_fp, st_ee, st_se, st_be, dec_tick, dec_wr} = '0;
    dec_wdata = 0;
  endtask

  task automatic step(string tag);
    logic [31:0] nd;
    #1;
    calc();
    if (tag == "") tag = tag_of(e_vec);
    checks++;
    if ({take, vector, prog_kind} !== {e_take, e_vec, e_kind}) begin
      errors++;
      $display("FAIL %s take/vec/kind %0b/%h/%0d expected %0b/%h/%0d",
               tag, take, vector, prog_kind, e_take, e_vec, e_kind);
    end
    checks++;
    if (dec_value !== m_dec) begin
      errors++;
      $display("FAIL R9 dec_value %h expected %h", dec_value, m_dec);
    end
    @(posedge clk);
    nd = dec_wr ? dec_wdata : dec_tick ? m_dec - 1 : m_dec;
    if (nd[31] & ~m_dec[31]) m_pend = 1;
    else if (e_take && e_vec == 16'h0900) m_pend = 0;
    m_dec = nd;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); rst_n = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (take !== 0 || vector !== 0 || prog_kind !== 0 || dec_value !== 0) begin
      errors++;
      $display("FAIL R1 reset take=%0b vec=%h dec=%h expected 0/0/0", take, vector, dec_value);
    end
    rst_n = 1;
    step("R1");
    ins_valid = 1; itlb_miss = 1; ins_illegal = 1; dtlb_miss = 1; step("R2");
    itlb_miss = 0; ins_priv = 1; st_pr = 1; ins_trap_hit = 1; step("R3 illegal");
    ins_illegal = 0; step("R3 priv");
    st_pr = 0; step("R3 trap");
    ins_trap_hit = 0; ins_priv = 0; step("R7");
    dtlb_miss = 0; ins_sprmove = 1; ins_spr_bad = 1; ins_spr_top = 1; st_pr = 1; step("R4 priv");
    ins_spr_top = 0; step("R4 none");
    ins_sprmove = 0; ins_fp = 1; step("R5 fp off");
    st_fp = 1; step("R5 fp on");
    ins_fp = 0; ins_sc = 1; st_se = 1; step("R6");
    ins_sc = 0; step("R8 se");
    st_se = 0; ins_branch = 1; st_be = 1; step("R8 be");
    st_be = 0; step("R11 idle");
    idle(); dec_wr = 1; dec_wdata = 1; step("R9 load");
    dec_wr = 0; dec_tick = 1; step("R9 tick");
    step("R9 wrap");
    dec_tick = 0; step("R10 pend ee=0");
    step("R10 held");
    st_ee = 1; ins_valid = 1; st_se = 1; step("R10 trace outranks");
    ins_valid = 0; step("R10 taken");
    step("R10 cleared");
    st_ee = 0; st_se = 0;
    for (int i = 0; i < 4000; i++) begin
      ins_valid    = ($urandom % 4) != 0;
      ins_illegal  = ($urandom % 16) == 0;
      ins_priv     = ($urandom % 8) == 0;
      ins_sprmove  = ($urandom % 4) == 0;
      ins_spr_bad  = $urandom % 2;
      ins_spr_top  = $urandom % 2;
      ins_trap_hit = ($urandom % 16) == 0;
      ins_fp       = ($urandom % 6) == 0;
      ins_sc       = ($urandom % 12) == 0;
      ins_branch   = ($urandom % 3) == 0;
      st_pr = $urandom % 2; st_fp = $urandom % 2; st_ee = $urandom % 2;
      st_se = ($urandom % 6) == 0; st_be = $urandom % 2;
      itlb_miss = ($urandom % 20) == 0;
      dtlb_miss = ($urandom % 12) == 0;
      dec_tick  = $urandom % 2;
      dec_wr    = ($urandom % 24) == 0;
      case ($urandom % 3)
        0: dec_wdata = $urandom % 6;
        1: dec_wdata = 32'h8000_0000 - ($urandom % 3);
        default: dec_wdata = $urandom;
      endcase
      step("");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule